// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits in the column path of a double-data-rate memory controller. It takes a mode register write and checks it. A write is a load strobe with a bank-select field and an address word. The block keeps the burst length, the burst order, the CAS latency and the operating-mode setting from that word. When a load carries a reserved code, the block refuses the whole word and raises a one-cycle error flag.

Each READ or WRITE burst begins with a start pulse and a starting column. For every beat of the programmed length, the block then emits one column address. All addresses stay inside an aligned block whose size equals the burst length. They wrap at the edge of that block. They follow either an additive (sequential) order or an XOR (interleaved) order.

The settings are captured when the burst starts, so a mode load during a burst takes effect only at the next burst. READ and WRITE bursts share the same settings.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid_o, last_beat_o, mode_err_o and dll_rst_o are 0, cas_half_o is 4, and the stored settings are burst length 2 in sequential order.
- R2: Address bits [2:0] give the burst length: 001 means 2 beats, 010 means 4 beats, 011 means 8 beats. A burst start while idle makes beat_valid_o high from the next cycle for exactly that many cycles. last_beat_o is high only together with the final address.
- R3: Bit [3] = 0 selects sequential order. The offset of beat k is (start offset + k) modulo the burst length.
- R4: Bit [3] = 1 selects interleaved order. The offset of beat k is the start offset XOR k.
- R5: The low 1, 2 or 3 column bits (for length 2, 4 or 8) are the offset within the block. Every higher column bit stays equal to the starting column for the whole burst.
- R6: Bits [6:4] give the CAS latency: 010 means 2, 110 means 2.5, 011 means 3. cas_half_o reports it in half cycles as 4, 5 or 6.
- R7: A load whose length code, latency code or operating-mode field (bits [12:7]) is reserved leaves every setting unchanged. It raises mode_err_o for exactly the one cycle after the load.
- R8: A load with a nonzero bank-select field changes no setting and raises no error.
- R9: A burst start that arrives while a burst is in progress is ignored. The running burst keeps its addresses and its length.
- R10: A setting from an accepted load is visible from the cycle after the load. A burst that has already started keeps the length and order it captured at its start.
- R11: In the operating-mode field (bits [12:7]), all zeros means normal operation. Only bit 8 set means normal operation with DLL reset and drives dll_rst_o to 1. Any other value is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_load_i | input | 1 | Mode register load strobe |
| mode_ba_i | input | BA_W | Bank-select field of the load |
| mode_addr_i | input | ADDR_W | Address word of the load |
| burst_start_i | input | 1 | Start a READ or WRITE burst |
| start_col_i | input | COL_W | Starting column of the burst |
| col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is active this cycle |
| last_beat_o | output | 1 | The current beat is the final one |
| cas_half_o | output | 3 | Stored CAS latency in half cycles |
| dll_rst_o | output | 1 | Stored operating mode requests DLL reset |
| mode_err_o | output | 1 | The previous load was refused as reserved |

## Verification
The hardest cases come from overlap between the two input streams. One is a start pulse that lands in the middle of a burst. The other is a mode load that changes the length and order while a burst is still running. The directed bursts place a second start and a new mode load on the first beat, then check every remaining beat against the settings captured at the start. Random loads then mix reserved codes and nonzero bank selects with valid words, so refused writes are followed straight away by bursts that reveal the stored length and order.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // log2 of the burst length; the values match the length code
  typedef enum logic [1:0] {
    BLEN_2 = 2'd1,
    BLEN_4 = 2'd2,
    BLEN_8 = 2'd3
  } blen_e;

  typedef struct packed {
    blen_e      blen;
    logic       ilv;
    logic [2:0] cas_half;
    logic       dll_rst;
  } mode_cfg_t;

  localparam int unsigned OFS_W = 3;  // widest in-block offset (8 beats)
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_cfg_t         cfg_o,
  output logic              err_o
);
  localparam int unsigned OP_W = ADDR_W - 7;
  localparam logic [OP_W-1:0] OP_NORMAL  = '0;
  localparam logic [OP_W-1:0] OP_DLL_RST = OP_W'(2);

  mode_cfg_t  cfg_q, cfg_d;
  logic       bl_ok, cl_ok, op_ok, sel;
  logic [2:0] cas_dec;

  always_comb begin
    bl_ok = (addr_i[2:0] == 3'b001) || (addr_i[2:0] == 3'b010) ||
            (addr_i[2:0] == 3'b011);
    cl_ok   = 1'b1;
    cas_dec = 3'd4;
    case (addr_i[6:4])
      3'b010:  cas_dec = 3'd4;
      3'b110:  cas_dec = 3'd5;
      3'b011:  cas_dec = 3'd6;
      default: cl_ok = 1'b0;
    endcase
    op_ok = (addr_i[ADDR_W-1:7] == OP_NORMAL) ||
            (addr_i[ADDR_W-1:7] == OP_DLL_RST);
    sel   = load_i && (ba_i == '0);

    cfg_d          = cfg_q;
    cfg_d.blen     = blen_e'(addr_i[1:0]);
    cfg_d.ilv      = addr_i[3];
    cfg_d.cas_half = cas_dec;
    cfg_d.dll_rst  = (addr_i[ADDR_W-1:7] == OP_DLL_RST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{blen: BLEN_2, ilv: 1'b0, cas_half: 3'd4, dll_rst: 1'b0};
      err_o <= 1'b0;
    end else begin
      err_o <= sel && !(bl_ok && cl_ok && op_ok);
      if (sel && bl_ok && cl_ok && op_ok) cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  blen_e            blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             active_q;
  logic [OFS_W-1:0] beat_q;
  logic [COL_W-1:0] col_q;
  blen_e            blen_q;
  logic             ilv_q;
  logic [OFS_W-1:0] mask, ofs;

  always_comb begin
    mask = OFS_W'((4'd1 << blen_q) - 4'd1);
    if (ilv_q) ofs = col_q[OFS_W-1:0] ^ beat_q;
    else       ofs = col_q[OFS_W-1:0] + beat_q;
    col_o = {col_q[COL_W-1:OFS_W], (col_q[OFS_W-1:0] & ~mask) | (ofs & mask)};
  end

  assign valid_o = active_q;
  assign last_o  = active_q && (beat_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      col_q    <= '0;
      blen_q   <= BLEN_2;
      ilv_q    <= 1'b0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        col_q    <= start_col_i;
        blen_q   <= blen_i;
        ilv_q    <= ilv_i;
      end
    end else begin
      beat_q <= beat_q + 1'b1;
      if (last_o) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [BA_W-1:0]   mode_ba_i,
  input  logic [ADDR_W-1:0] mode_addr_i,
  input  logic              burst_start_i,
  input  logic [COL_W-1:0]  start_col_i,
  output logic [COL_W-1:0]  col_o,
  output logic              beat_valid_o,
  output logic              last_beat_o,
  output logic [2:0]        cas_half_o,
  output logic              dll_rst_o,
  output logic              mode_err_o
);
  mode_cfg_t cfg;

  burst_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .ba_i   (mode_ba_i),
    .addr_i (mode_addr_i),
    .cfg_o  (cfg),
    .err_o  (mode_err_o)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (burst_start_i),
    .start_col_i (start_col_i),
    .blen_i      (cfg.blen),
    .ilv_i       (cfg.ilv),
    .col_o       (col_o),
    .valid_o     (beat_valid_o),
    .last_o      (last_beat_o)
  );

  assign cas_half_o = cfg.cas_half;
  assign dll_rst_o  = cfg.dll_rst;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_load_i,
  input logic [BA_W-1:0]   mode_ba_i,
  input logic [ADDR_W-1:0] mode_addr_i,
  input logic              burst_start_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic [COL_W-1:0]  col_o,
  input logic              beat_valid_o,
  input logic              last_beat_o,
  input logic [2:0]        cas_half_o,
  input logic              dll_rst_o,
  input logic              mode_err_o
);
  p_last_in_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat_o |-> beat_valid_o);

  p_idle_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat_o |=> !beat_valid_o);

  p_start_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_start_i && !beat_valid_o |=> beat_valid_o);

  p_block_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !last_beat_o |=>
      beat_valid_o && (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

  p_cas_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_half_o == 3'd4) || (cas_half_o == 3'd5) || (cas_half_o == 3'd6));

  p_err_after_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> $past(mode_load_i && (mode_ba_i == '0)));

  p_bank_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_load_i && (mode_ba_i != '0) |=>
      $stable(cas_half_o) && $stable(dll_rst_o) && !mode_err_o);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !last_beat_o && burst_start_i |=>
      beat_valid_o && (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));
endmodule

bind burst_col_seq burst_col_seq_chk #(
  .COL_W(COL_W), .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (.*);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/100ps
module burst_col_seq_tb;
  localparam int COL_W = 10, ADDR_W = 13, BA_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_load_i = 1'b0, burst_start_i = 1'b0;
  logic [BA_W-1:0] mode_ba_i = '0;
  logic [ADDR_W-1:0] mode_addr_i = '0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [COL_W-1:0] col_o;
  logic beat_valid_o, last_beat_o, dll_rst_o, mode_err_o;
  logic [2:0] cas_half_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  int m_lg = 1, m_il = 0, m_cas = 4, m_dll = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .ADDR_W(ADDR_W), .BA_W(BA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_load_i(mode_load_i),
    .mode_ba_i(mode_ba_i), .mode_addr_i(mode_addr_i),
    .burst_start_i(burst_start_i), .start_col_i(start_col_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .last_beat_o(last_beat_o),
    .cas_half_o(cas_half_o), .dll_rst_o(dll_rst_o), .mode_err_o(mode_err_o));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(int op, int cl, int bt, int bl);
    return ADDR_W'((op << 7) | (cl << 4) | (bt << 3) | bl);
  endfunction

  function automatic int exp_col(int col, int lg, int il, int b);
    int mask = (1 << lg) - 1;
    int ofs = il ? ((col & 7) ^ b) : ((col & 7) + b);
    return (col & ~mask) | (ofs & mask);
  endfunction

  task automatic do_load(int ba, int op, int cl, int bt, int bl, string tag);
    int ok, cas;
    ok = 1; cas = 4;
    if (!(bl >= 1 && bl <= 3)) ok = 0;
    case (cl) 2: cas = 4; 6: cas = 5; 3: cas = 6; default: ok = 0; endcase
    if (!(op == 0 || op == 2)) ok = 0;
    @(negedge clk);
    mode_load_i = 1'b1; mode_ba_i = BA_W'(ba); mode_addr_i = mk(op, cl, bt, bl);
    @(negedge clk);
    mode_load_i = 1'b0;
    if (ba == 0 && ok == 1) begin
      m_lg = bl; m_il = bt; m_cas = cas; m_dll = (op == 2);
    end
    check({tag, " R7/R8 err flag"}, int'(mode_err_o), (ba == 0 && ok == 0));
    check({tag, " R6/R10 cas"}, int'(cas_half_o), m_cas);
    check({tag, " R11 dll"}, int'(dll_rst_o), m_dll);
    if (ba == 0 && ok == 0) begin
      @(negedge clk);
      check({tag, " R7 err one cycle"}, int'(mode_err_o), 0);
    end
  endtask

  // intr: 0 none, 1 second start on beat 0, 2 mode load on beat 0
  task automatic run_burst(int col, int intr, string tag);
    int lg = m_lg, il = m_il, len = 1 << m_lg;
    @(negedge clk);
    burst_start_i = 1'b1; start_col_i = COL_W'(col);
    @(negedge clk);
    burst_start_i = 1'b0;
    for (int b = 0; b < len; b++) begin
      check({tag, " R2 valid"}, int'(beat_valid_o), 1);
      check({tag, il ? " R4/R5 col" : " R3/R5 col"}, int'(col_o), exp_col(col, lg, il, b));
      check({tag, " R2 last"}, int'(last_beat_o), int'(b == len - 1));
      if (b == 0 && intr == 1) begin
        burst_start_i = 1'b1; start_col_i = ~COL_W'(col);  // R9
      end
      if (b == 0 && intr == 2) begin
        mode_load_i = 1'b1; mode_ba_i = '0; mode_addr_i = mk(0, 3, 1, 3);  // R10
      end
      @(negedge clk);
      burst_start_i = 1'b0;
      if (mode_load_i) begin
        mode_load_i = 1'b0;
        m_lg = 3; m_il = 1; m_cas = 6; m_dll = 0;
      end
    end
    check({tag, " R2/R9 idle after burst"}, int'(beat_valid_o), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    check("R1 valid", int'(beat_valid_o), 0);
    check("R1 last", int'(last_beat_o), 0);
    check("R1 err", int'(mode_err_o), 0);
    check("R1 dll", int'(dll_rst_o), 0);
    check("R1 cas", int'(cas_half_o), 4);
    rst_ni = 1'b1;
    run_burst(10'h005, 0, "R1 default burst");
    do_load(0, 0, 2, 0, 2, "bl4 seq");
    run_burst(10'h00E, 0, "bl4 seq wrap");
    do_load(0, 0, 6, 1, 3, "bl8 ilv");
    run_burst(10'h2AD, 0, "bl8 ilv");
    do_load(0, 2, 3, 0, 3, "bl8 seq dll");
    run_burst(10'h3FF, 0, "bl8 seq top");
    do_load(0, 0, 2, 0, 4, "reserved bl");
    do_load(0, 0, 1, 1, 1, "reserved cl");
    do_load(0, 1, 2, 1, 1, "reserved op");
    do_load(1, 0, 2, 1, 1, "bank1");
    do_load(2, 0, 6, 1, 2, "bank2");
    run_burst(10'h123, 0, "after refused");
    do_load(0, 0, 2, 0, 2, "bl4 again");
    run_burst(10'h1F6, 1, "R9 start mid");
    run_burst(10'h0C1, 2, "R10 load mid");
    run_burst(10'h0C1, 0, "R10 new cfg");
    do_load(0, 0, 2, 0, 1, "bl2");
    run_burst(10'h001, 1, "R9 bl2 start mid");
    for (int i = 0; i < 60; i++) begin
      int ba, op, cl, bt, bl;
      ba = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
      bl = ($urandom % 4 == 0) ? int'($urandom % 8) : int'(1 + $urandom % 3);
      cl = ($urandom % 4 == 0) ? int'($urandom % 8) : ((i % 3 == 0) ? 2 : (i % 3 == 1) ? 3 : 6);
      op = ($urandom % 5 == 0) ? int'($urandom % 64) : int'(($urandom % 2) * 2);
      bt = int'($urandom % 2);
      do_load(ba, op, cl, bt, bl, "rand load");
      run_burst(int'($urandom % 1024), int'($urandom % 3), "rand burst");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule